// File: doc/BRIEF.md
# Segment Waveform Player with Duration Offsets

This block plays back one stored waveform on request and produces a signed drive amplitude, one new value per sample tick. A waveform is a short list of segment records held in an external memory. Each record either holds one level for a number of ticks, or ramps linearly from a start level to an end level over a number of ticks. A sequencer asks for a waveform by number with a start pulse while the player is ready. The player reads the records through a synchronous read port and reports the end of playback with a one-cycle done pulse.

Before anything is played, the player makes a first pass over the records. It finds the segment with the highest positive level, which becomes the overdrive segment, and the segment with the lowest negative level, which becomes the brake segment. During playback, every segment duration has a signed offset added to it. The offset is chosen by the segment's role: overdrive, brake, other positive (sustain-positive) or other negative (sustain-negative). A ramp is spread over its adjusted length. The offsets can stretch or shrink a whole library of waveforms to suit one actuator without rewriting memory.

Top module: `wave_player`

## Requirements
- R1: After reset `amp_o` is 0, `done_o` is 0 and `ready_o` is 1.
- R2: A `start_i` pulse while `ready_o` is 1 latches `wave_id_i`, and `ready_o` falls in the next cycle. While `ready_o` is 0, `start_i` is ignored and the waveform in progress plays on unchanged.
- R3: A hold segment (ramp bit 0) outputs its start level on each of its adjusted-duration ticks.
- R4: On its k-th tick (k = 1..D, where D is the adjusted duration), a ramp segment (ramp bit 1) outputs start + ((end − start) × k) / D. The division truncates toward zero, so the last tick lands exactly on the end level.
- R5: The role level of a segment is its start level for a hold and its end level for a ramp. The first segment with the largest strictly positive role level takes the overdrive offset `ofs_od_i`.
- R6: The first segment with the smallest strictly negative role level takes the brake offset `ofs_br_i`.
- R7: Any other segment with a positive role level takes `ofs_sp_i`, any other with a negative role level takes `ofs_sn_i`, and a segment with role level 0 takes no offset.
- R8: The adjusted duration is the stored duration plus the signed 8-bit offset, clamped to at least 1 tick. A stored duration of 0 therefore plays for 1 tick.
- R9: Playback ends after the segment whose last bit is set, or after segment 2^SEG_LG − 1, whichever comes first. On the next tick after the final segment's last tick, `amp_o` becomes 0, `done_o` is 1 for exactly one cycle, and `ready_o` is 1.
- R10: `amp_o` changes only in the cycle after a cycle in which `tick_i` is 1. A tick that arrives while idle or while records are being read has no effect. Ticks must be at least 4 cycles apart.
- R11: The memory address is {waveform id, segment index}, and data is expected one cycle after the address. A record is, MSB first: last bit, ramp bit, start level (8 bits, signed), end level (8 bits, signed), duration (8 bits, unsigned).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken while ready_o is 1 |
| wave_id_i | input | ID_W | Waveform number to play |
| ready_o | output | 1 | Player idle and able to accept a start |
| mem_addr_o | output | ID_W+SEG_LG | Segment record address |
| mem_data_i | input | 26 | Segment record read one cycle after the address |
| tick_i | input | 1 | Sample tick |
| ofs_od_i | input | 8 | Signed overdrive duration offset |
| ofs_sp_i | input | 8 | Signed sustain-positive duration offset |
| ofs_sn_i | input | 8 | Signed sustain-negative duration offset |
| ofs_br_i | input | 8 | Signed brake duration offset |
| amp_o | output | 8 | Signed drive amplitude |
| done_o | output | 1 | One-cycle pulse at the end of playback |

## Verification
A wrongly captured overdrive or brake index, or a wrong choice of role, shows up as a segment that plays too long or too short. The amplitude sequence then drifts from the expected one at the first tick after that segment's expected end, which is no later than the following segment's first tick. A wrong elapsed count or ramp arithmetic changes `amp_o` on the very tick it occurs. A wrong end condition shows up as a missing, late or early `done_o` pulse. The bench sweeps all four offsets over a set of values that includes clamping and stretching, on waveforms that exercise ties, zero levels, negative ramps and the end-of-slot stop, and compares every tick with an arithmetic model.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int LVL_W = 8;
  localparam int DUR_W = 8;
  localparam int OFS_W = 8;
  localparam int ADJ_W = DUR_W + 1;
  localparam int REC_W = 2 + 2 * LVL_W + DUR_W;

  typedef logic signed [LVL_W-1:0] lvl_t;
  typedef logic [DUR_W-1:0]        dur_t;
  typedef logic signed [OFS_W-1:0] ofs_t;
  typedef logic [ADJ_W-1:0]        adj_t;

  typedef struct packed {
    logic last;
    logic ramp;
    lvl_t lvl_a;
    lvl_t lvl_b;
    dur_t dur;
  } seg_t;

  typedef enum logic [2:0] {ROLE_NONE, ROLE_OD, ROLE_SP, ROLE_SN, ROLE_BR} role_t;

  // level used to classify a segment
  function automatic lvl_t role_level(input seg_t s);
    return s.ramp ? s.lvl_b : s.lvl_a;
  endfunction

  // stored duration plus signed offset, never below one tick
  function automatic adj_t adjust_dur(input dur_t d, input ofs_t o);
    int s;
    s = int'(d) + int'(o);
    if (s < 1) s = 1;
    return adj_t'(s);
  endfunction

  // interpolated level on tick k of a ramp lasting d ticks
  function automatic lvl_t ramp_point(input lvl_t a, input lvl_t b, input adj_t k, input adj_t d);
    int span;
    int q;
    if (d == '0) return a;
    span = int'(b) - int'(a);
    q = (span * int'(k)) / int'(d);
    return lvl_t'(int'(a) + q);
  endfunction
endpackage

// File: rtl/wp_role_scan.sv
module wp_role_scan
  import wp_pkg::*;
#(
  parameter int SEG_LG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [SEG_LG-1:0] idx,
  input  lvl_t              lvl,
  output logic              od_ok,
  output logic [SEG_LG-1:0] od_idx,
  output logic              br_ok,
  output logic [SEG_LG-1:0] br_idx
);
  lvl_t max_q, min_q;

  // starting from 0 means only strictly positive/negative levels qualify;
  // strict compares keep the first of equal extremes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q  <= '0;
      min_q  <= '0;
      od_ok  <= 1'b0;
      br_ok  <= 1'b0;
      od_idx <= '0;
      br_idx <= '0;
    end else if (clr) begin
      max_q  <= '0;
      min_q  <= '0;
      od_ok  <= 1'b0;
      br_ok  <= 1'b0;
      od_idx <= '0;
      br_idx <= '0;
    end else if (en) begin
      if (lvl > max_q) begin
        max_q  <= lvl;
        od_idx <= idx;
        od_ok  <= 1'b1;
      end
      if (lvl < min_q) begin
        min_q  <= lvl;
        br_idx <= idx;
        br_ok  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wp_dur_sel.sv
module wp_dur_sel
  import wp_pkg::*;
#(
  parameter int SEG_LG = 2
) (
  input  logic [SEG_LG-1:0] idx,
  input  lvl_t              lvl,
  input  dur_t              dur,
  input  logic              od_ok,
  input  logic [SEG_LG-1:0] od_idx,
  input  logic              br_ok,
  input  logic [SEG_LG-1:0] br_idx,
  input  ofs_t              ofs_od,
  input  ofs_t              ofs_sp,
  input  ofs_t              ofs_sn,
  input  ofs_t              ofs_br,
  output role_t             role,
  output adj_t              adj
);
  ofs_t ofs;

  always_comb begin
    if (od_ok && idx == od_idx)      role = ROLE_OD;
    else if (br_ok && idx == br_idx) role = ROLE_BR;
    else if (lvl > 0)                role = ROLE_SP;
    else if (lvl < 0)                role = ROLE_SN;
    else                             role = ROLE_NONE;

    case (role)
      ROLE_OD: ofs = ofs_od;
      ROLE_SP: ofs = ofs_sp;
      ROLE_SN: ofs = ofs_sn;
      ROLE_BR: ofs = ofs_br;
      default: ofs = '0;
    endcase

    adj = adjust_dur(dur, ofs);
  end
endmodule

// File: rtl/wp_seg_run.sv
module wp_seg_run
  import wp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  input  seg_t seg,
  input  logic last_in,
  input  adj_t dur_adj,
  output lvl_t val,
  output logic fin,
  output logic last
);
  lvl_t a_q, b_q;
  logic ramp_q;
  adj_t d_q, k_q, k_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      ramp_q <= 1'b0;
      d_q    <= '0;
      k_q    <= '0;
      last   <= 1'b0;
    end else if (load) begin
      a_q    <= seg.lvl_a;
      b_q    <= seg.lvl_b;
      ramp_q <= seg.ramp;
      d_q    <= dur_adj;
      k_q    <= '0;
      last   <= last_in;
    end else if (step) begin
      k_q <= k_nxt;
    end
  end

  assign k_nxt = k_q + adj_t'(1);
  assign val   = ramp_q ? ramp_point(a_q, b_q, k_nxt, d_q) : a_q;
  assign fin   = (k_nxt == d_q);
endmodule

// File: rtl/wave_player.sv
module wave_player
  import wp_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int SEG_LG = 2,
  localparam int ADDR_W = ID_W + SEG_LG
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [ID_W-1:0]         wave_id_i,
  output logic                    ready_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic [REC_W-1:0]        mem_data_i,
  input  logic                    tick_i,
  input  logic signed [OFS_W-1:0] ofs_od_i,
  input  logic signed [OFS_W-1:0] ofs_sp_i,
  input  logic signed [OFS_W-1:0] ofs_sn_i,
  input  logic signed [OFS_W-1:0] ofs_br_i,
  output logic signed [LVL_W-1:0] amp_o,
  output logic                    done_o
);
  localparam logic [SEG_LG-1:0] IDX_MAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_SCAN_A, S_SCAN_D, S_PLAY_A, S_PLAY_D, S_RUN, S_END} st_t;

  st_t               st_q;
  logic [ID_W-1:0]   id_q;
  logic [SEG_LG-1:0] idx_q;
  lvl_t              amp_q;
  logic              done_q;

  // named internal events
  seg_t  seg_w;
  lvl_t  rlvl;
  logic  idx_last, scan_clr, scan_en, seg_load, run_step;
  logic  od_ok, br_ok;
  logic [SEG_LG-1:0] od_idx, br_idx;
  role_t seg_role;
  adj_t  adj_dur;
  lvl_t  run_val;
  logic  run_fin, run_last;

  assign seg_w    = seg_t'(mem_data_i);
  assign rlvl     = role_level(seg_w);
  assign idx_last = seg_w.last || (idx_q == IDX_MAX);
  assign scan_clr = (st_q == S_IDLE) && start_i;
  assign scan_en  = (st_q == S_SCAN_D);
  assign seg_load = (st_q == S_PLAY_D);
  assign run_step = (st_q == S_RUN) && tick_i;

  wp_role_scan #(.SEG_LG(SEG_LG)) scan_i (
    .clk(clk), .rst_n(rst_n), .clr(scan_clr), .en(scan_en),
    .idx(idx_q), .lvl(rlvl),
    .od_ok(od_ok), .od_idx(od_idx), .br_ok(br_ok), .br_idx(br_idx)
  );

  wp_dur_sel #(.SEG_LG(SEG_LG)) sel_i (
    .idx(idx_q), .lvl(rlvl), .dur(seg_w.dur),
    .od_ok(od_ok), .od_idx(od_idx), .br_ok(br_ok), .br_idx(br_idx),
    .ofs_od(ofs_od_i), .ofs_sp(ofs_sp_i), .ofs_sn(ofs_sn_i), .ofs_br(ofs_br_i),
    .role(seg_role), .adj(adj_dur)
  );

  wp_seg_run run_i (
    .clk(clk), .rst_n(rst_n), .load(seg_load), .step(run_step),
    .seg(seg_w), .last_in(idx_last), .dur_adj(adj_dur),
    .val(run_val), .fin(run_fin), .last(run_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      id_q   <= '0;
      idx_q  <= '0;
      amp_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          id_q  <= wave_id_i;
          idx_q <= '0;
          st_q  <= S_SCAN_A;
        end
        S_SCAN_A: st_q <= S_SCAN_D;
        S_SCAN_D: begin
          if (idx_last) begin
            idx_q <= '0;
            st_q  <= S_PLAY_A;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= S_SCAN_A;
          end
        end
        S_PLAY_A: st_q <= S_PLAY_D;
        S_PLAY_D: st_q <= S_RUN;
        S_RUN: if (tick_i) begin
          amp_q <= run_val;
          if (run_fin) begin
            if (run_last) st_q <= S_END;
            else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= S_PLAY_A;
            end
          end
        end
        S_END: if (tick_i) begin
          amp_q  <= '0;
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ready_o    = (st_q == S_IDLE);
  assign mem_addr_o = {id_q, idx_q};
  assign amp_o      = amp_q;
  assign done_o     = done_q;
endmodule

// File: rtl/wave_player_chk.sv
module wave_player_chk
  import wp_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int SEG_LG = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic                    ready_o,
  input logic                    tick_i,
  input logic                    done_o,
  input logic signed [LVL_W-1:0] amp_o,
  input logic [ID_W+SEG_LG-1:0]  mem_addr_o,
  input logic [ID_W-1:0]         id_q,
  input logic                    seg_load,
  input logic [ADJ_W-1:0]        adj_dur
);
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && start_i) |=> !ready_o);

  a_r8_min_dur: assert property (@(posedge clk) disable iff (!rst_n)
    seg_load |-> (adj_dur != '0));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (amp_o == '0) && ready_o);

  a_r10_amp_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(amp_o));

  a_r11_addr_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> (mem_addr_o[ID_W+SEG_LG-1:SEG_LG] == id_q));
endmodule

bind wave_player wave_player_chk #(.ID_W(ID_W), .SEG_LG(SEG_LG)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_o(ready_o),
  .tick_i(tick_i), .done_o(done_o), .amp_o(amp_o), .mem_addr_o(mem_addr_o),
  .id_q(id_q), .seg_load(seg_load), .adj_dur(adj_dur)
);

// File: tb/wave_player_tb_top.sv
module wave_player_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] wave_id = '0;
  logic ready;
  logic [4:0] addr;
  logic [25:0] rdata = '0;
  logic tick = 1'b0;
  logic signed [7:0] o_od = '0, o_sp = '0, o_sn = '0, o_br = '0;
  logic signed [7:0] amp;
  logic done;

  int checks = 0;
  int errors = 0;
  logic [25:0] mem [0:31];

  always #2 clk = ~clk;
  always @(posedge clk) rdata <= mem[addr];

  wave_player dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .wave_id_i(wave_id),
    .ready_o(ready), .mem_addr_o(addr), .mem_data_i(rdata), .tick_i(tick),
    .ofs_od_i(o_od), .ofs_sp_i(o_sp), .ofs_sn_i(o_sn), .ofs_br_i(o_br),
    .amp_o(amp), .done_o(done)
  );

  function automatic logic [25:0] rec(input bit lst, input bit rmp, input int a, input int b, input int d);
    return {lst, rmp, 8'(a), 8'(b), 8'(d)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // arithmetic model of one playback
  task automatic build_expect(input int id, input int od, input int sp, input int sn, input int br,
                              ref int exp_q[$], ref string tag_q[$]);
    int n, best_p, best_n, i_od, i_br;
    int rl [4];
    n = 0;
    for (int i = 0; i < 4; i++) begin
      logic [25:0] m = mem[id*4+i];
      rl[i] = m[24] ? int'($signed(m[15:8])) : int'($signed(m[23:16]));
      n++;
      if (m[25]) break;
    end
    best_p = 0; best_n = 0; i_od = -1; i_br = -1;
    for (int i = 0; i < n; i++) begin
      if (rl[i] > best_p) begin best_p = rl[i]; i_od = i; end
      if (rl[i] < best_n) begin best_n = rl[i]; i_br = i; end
    end
    for (int i = 0; i < n; i++) begin
      logic [25:0] m = mem[id*4+i];
      int a = int'($signed(m[23:16]));
      int b = int'($signed(m[15:8]));
      int off, dd;
      string t;
      if (i == i_od)      begin off = od; t = "R5"; end
      else if (i == i_br) begin off = br; t = "R6"; end
      else if (rl[i] > 0) begin off = sp; t = "R7"; end
      else if (rl[i] < 0) begin off = sn; t = "R7"; end
      else                begin off = 0;  t = "R7"; end
      dd = int'(m[7:0]) + off;
      if (dd < 1) begin dd = 1; t = {t, " R8"}; end
      for (int k = 1; k <= dd; k++) begin
        exp_q.push_back(m[24] ? a + ((b - a) * k) / dd : a);
        tag_q.push_back($sformatf("%s %s id%0d seg%0d tick%0d", m[24] ? "R4" : "R3", t, id, i, k));
      end
    end
  endtask

  task automatic run_wave(input int id, input int od, input int sp, input int sn, input int br,
                          input bit poke);
    int exp_q[$];
    string tag_q[$];
    build_expect(id, od, sp, sn, br, exp_q, tag_q);
    o_od = 8'(od); o_sp = 8'(sp); o_sn = 8'(sn); o_br = 8'(br);
    @(negedge clk); start = 1'b1; wave_id = 3'(id);
    @(negedge clk); start = 1'b0;
    check(!ready, "R2 ready low after start", int'(ready), 0);
    check(int'(addr[4:2]) == id, "R11 address carries id", int'(addr[4:2]), id);
    repeat (14) @(negedge clk);
    if (poke) begin
      start = 1'b1; wave_id = 3'(id ^ 1);
      @(negedge clk); start = 1'b0;
    end
    foreach (exp_q[i]) begin
      tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      check(amp == 8'(exp_q[i]), tag_q[i], int'(amp), exp_q[i]);
      check(!done, "R9 no early done", int'(done), 0);
      repeat (3) @(negedge clk);
      check(amp == 8'(exp_q[i]), "R10 amp held between ticks", int'(amp), exp_q[i]);
    end
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check(amp == 0, "R9 amplitude zero at end", int'(amp), 0);
    check(done, "R9 done pulse", int'(done), 1);
    check(ready, "R9 ready at end", int'(ready), 1);
    @(negedge clk);
    check(!done, "R9 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sw [4];
    sw = '{-128, -2, 0, 3};
    for (int i = 0; i < 32; i++) mem[i] = '0;
    // id0: overdrive hold, positive ramp, brake hold, negative ramp (last)
    mem[0]  = rec(0, 0, 100, 0, 3);
    mem[1]  = rec(0, 1, 100, 40, 4);
    mem[2]  = rec(0, 0, -90, 0, 2);
    mem[3]  = rec(1, 1, 0, -30, 3);
    // id1: zero level, tied positives, full-swing ramp; stops at slot end
    mem[4]  = rec(0, 0, 0, 0, 2);
    mem[5]  = rec(0, 0, 50, 0, 2);
    mem[6]  = rec(0, 0, 50, 0, 2);
    mem[7]  = rec(0, 1, 127, -128, 5);
    // id2: single zero-length hold
    mem[8]  = rec(1, 0, 5, 0, 0);
    // id3: shallow ramp with truncation, then unused records
    mem[12] = rec(1, 1, 10, 13, 7);
    mem[13] = rec(0, 0, 99, 0, 9);

    repeat (3) @(negedge clk);
    check(amp == 0, "R1 reset amplitude", int'(amp), 0);
    check(!done, "R1 reset done", int'(done), 0);
    check(ready, "R1 reset ready", int'(ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check(amp == 0, "R10 idle tick ignored", int'(amp), 0);
    check(!done, "R10 idle tick no done", int'(done), 0);

    run_wave(2, 0, 0, 0, 0, 0);
    run_wave(2, -5, 0, 0, 0, 0);
    run_wave(3, 0, 0, 0, 0, 0);
    run_wave(3, 4, 0, 0, 0, 1);
    run_wave(0, 0, 0, 0, 0, 1);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            run_wave(0, sw[a], sw[b], sw[c], sw[d], 0);
            run_wave(1, sw[a], sw[b], sw[c], sw[d], 0);
          end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule